// File: doc/BRIEF.md
# UART Command and Status Controller

This block is the register-facing control logic of a simple UART. Software reaches it through a synchronous register bus with a 6-bit byte offset, read and write strobes and 8-bit data. Through that bus it sees two mode registers that share one offset behind an auto-advancing pointer, a status register, an interrupt status register and an interrupt mask. A command register packs three independent fields into one byte. One field gives miscellaneous resets, one gives the transmitter enable action and one gives the receiver enable action.

On the transmit side the block keeps one holding byte. It hands that byte to a serial transmitter with a one-cycle send strobe, and it holds the strobe back while the transmitter reports busy. On the receive side the block observes the fill level of an external receive FIFO. It pops that FIFO when software reads the data offset, flushes it on a receiver reset, and tells the FIFO when it may accept new bytes. Sticky error flags and a delta-break flag are set by receive-side event pulses. A single level interrupt output combines the interrupt status with the mask. Bit 6 of the first mode register selects the receive interrupt source: either "FIFO full" or "data ready".

Top module: `ucs_top`

## Requirements
- R1: After reset the status register (offset 0x04) reads 0x08, meaning only the transmitter-empty bit (bit3) is set while the FIFO is empty. Both enables are off, the interrupt status (offset 0x14) reads 0x00, `irq` is low, `rx_accept` is low and the illegal-command flag (offset 0x1C bit0) reads 0.
- R2: Reads and writes at offset 0x00 reach mode register 1 on the first access, then mode register 2 on every later access. A command byte whose bits [6:4] equal 1 returns the pointer to mode register 1. Read data appears on `bus_rdata` in the cycle after the read strobe.
- R3: A write to offset 0x0C loads the holding byte and clears status bit3. While the transmitter is enabled, bit3 is clear and `tx_busy` is low, `tx_send` is high for one cycle with the byte on `tx_byte`, and bit3 is set again in the next cycle. While the transmitter is disabled or busy, the byte is held and nothing is sent.
- R4: Command bits [3:2] = 1 enable the transmitter and = 2 disable it. Status bit2 (transmitter ready) is 1 exactly while the transmitter is enabled.
- R5: Command bits [1:0] = 1 enable the receiver and = 2 disable it. `rx_accept` is high while the receiver is enabled and the FIFO is not full.
- R6: Status bit0 is 1 while `rx_level` is nonzero. Status bit1 is 1 while `rx_level` equals the FIFO depth (4). A read at offset 0x0C returns `rx_data` and raises `rx_pop` for that cycle only if the FIFO is nonempty.
- R7: Miscellaneous code 2 (command bits [6:4]) pulses `rx_flush` and disables the receiver. Code 3 sets status bit3, disables the transmitter and discards any held byte.
- R8: Pulses on `rx_evt` bits 0..3 (overrun, parity, framing, break) set sticky status bits 4..7. Miscellaneous code 4 clears all four bits and the illegal-command flag, and this clear wins over an event in the same cycle.
- R9: A break event sets interrupt status bit2. Miscellaneous code 5 clears that bit without touching status bit7.
- R10: Interrupt status bit0 equals status bit2. Interrupt status bit1 equals status bit1 when mode register 1 bit6 is set, and status bit0 otherwise. A write to offset 0x14 loads the mask, and `irq` is high whenever interrupt status AND mask is nonzero.
- R11: A transmitter or receiver field of value 3 leaves that enable unchanged and sets the sticky illegal-command flag, which reads at offset 0x1C bit0.
- R12: Within one command byte the miscellaneous action applies first and the enable fields after it, so a transmitter reset combined with an enable leaves the transmitter enabled. Miscellaneous codes 0, 6 and 7 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 6 | Byte offset of the register access |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid the cycle after `bus_rd` |
| tx_busy | input | 1 | Serial transmitter cannot take a byte |
| tx_send | output | 1 | One-cycle strobe handing `tx_byte` to the transmitter |
| tx_byte | output | 8 | Held transmit byte |
| rx_level | input | 3 | Number of bytes in the receive FIFO |
| rx_data | input | 8 | Oldest byte in the receive FIFO |
| rx_evt | input | 4 | Receive event pulses: overrun, parity, framing, break |
| rx_pop | output | 1 | Remove the oldest FIFO byte |
| rx_flush | output | 1 | Empty the receive FIFO |
| rx_accept | output | 1 | FIFO may take new bytes |
| irq | output | 1 | Level interrupt request |

## Verification
The hardest situation to reach is a single command byte that carries a miscellaneous reset and an enable action at once, because the outcome depends on an ordering that no single field shows. The bench writes combined bytes such as a transmitter reset with an enable, and a transmitter enable with a reserved receiver code. It then reads status and the illegal flag back. A held transmit byte that meets a reset while the transmitter is busy is reached by holding `tx_busy` high across a buffer write and the reset command, then releasing it and confirming that no send strobe follows.

// File: rtl/ucs_pkg.sv
// Shared constants and types of the UART command and status controller.
// Assumes an 8-bit register bus with a 6-bit byte offset.
package ucs_pkg;
    localparam int DW = 8;
    localparam int AW = 6;

    localparam logic [AW-1:0] OFS_MODE = 6'h00;
    localparam logic [AW-1:0] OFS_STAT = 6'h04;
    localparam logic [AW-1:0] OFS_CMD  = 6'h08;
    localparam logic [AW-1:0] OFS_DATA = 6'h0C;
    localparam logic [AW-1:0] OFS_INT  = 6'h14;
    localparam logic [AW-1:0] OFS_FLAG = 6'h1C;

    // Miscellaneous command codes, command bits [6:4]
    typedef enum logic [2:0] {
        MISC_NOP     = 3'd0,
        MISC_PTR_RST = 3'd1,
        MISC_RX_RST  = 3'd2,
        MISC_TX_RST  = 3'd3,
        MISC_ERR_RST = 3'd4,
        MISC_BRK_CLR = 3'd5,
        MISC_BRK_ON  = 3'd6,
        MISC_BRK_OFF = 3'd7
    } misc_cmd_e;

    // Enable-field codes, command bits [3:2] and [1:0]
    typedef enum logic [1:0] {
        EN_KEEP = 2'd0,
        EN_ON   = 2'd1,
        EN_OFF  = 2'd2,
        EN_RSVD = 2'd3
    } en_cmd_e;

    // Decoded one-cycle actions of a command write
    typedef struct packed {
        logic ptr_rst;
        logic rx_rst;
        logic tx_rst;
        logic err_rst;
        logic brk_clr;
        logic tx_on;
        logic tx_off;
        logic rx_on;
        logic rx_off;
        logic illegal;
    } cmd_act_t;
endpackage

// File: rtl/ucs_cmd_decode.sv
// Command decoder: turns one command write into action strobes.
// Purely combinational; actions are valid only in the write cycle.
module ucs_cmd_decode
    import ucs_pkg::*;
(
    input  logic       cmd_we,
    input  logic [6:0] cmd_bits,
    output cmd_act_t   act
);
    misc_cmd_e misc;
    en_cmd_e   txf;
    en_cmd_e   rxf;

    assign misc = misc_cmd_e'(cmd_bits[6:4]);
    assign txf  = en_cmd_e'(cmd_bits[3:2]);
    assign rxf  = en_cmd_e'(cmd_bits[1:0]);

    // Map each field to its strobe, gated by the write
    always_comb begin
        act         = '0;
        act.ptr_rst = cmd_we && (misc == MISC_PTR_RST);
        act.rx_rst  = cmd_we && (misc == MISC_RX_RST);
        act.tx_rst  = cmd_we && (misc == MISC_TX_RST);
        act.err_rst = cmd_we && (misc == MISC_ERR_RST);
        act.brk_clr = cmd_we && (misc == MISC_BRK_CLR);
        act.tx_on   = cmd_we && (txf == EN_ON);
        act.tx_off  = cmd_we && (txf == EN_OFF);
        act.rx_on   = cmd_we && (rxf == EN_ON);
        act.rx_off  = cmd_we && (rxf == EN_OFF);
        act.illegal = cmd_we && ((txf == EN_RSVD) || (rxf == EN_RSVD));
    end
endmodule

// File: rtl/ucs_mode_regs.sv
// Two mode registers behind one offset. A pointer selects which one is
// accessed; it moves to the second after any access and returns only on
// a pointer-reset command. Assumes access and pointer reset never coincide.
module ucs_mode_regs #(
    parameter int DW = 8,
    parameter int RXSEL_BIT = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          acc,
    input  logic          we,
    input  logic [DW-1:0] wdata,
    input  logic          ptr_rst,
    output logic [DW-1:0] rd_val,
    output logic          rx_full_sel
);
    logic [1:0][DW-1:0] mr_q;
    logic               ptr_q;

    // Pointer update
    always_ff @(posedge clk) begin
        if (!rst_n)       ptr_q <= 1'b0;
        else if (ptr_rst) ptr_q <= 1'b0;
        else if (acc)     ptr_q <= 1'b1;
    end

    // Register storage, one generate slot per mode register
    for (genvar g = 0; g < 2; g++) begin : g_mr
        always_ff @(posedge clk) begin
            if (!rst_n)                       mr_q[g] <= '0;
            else if (we && (ptr_q == 1'(g)))  mr_q[g] <= wdata;
        end
    end

    assign rd_val      = mr_q[ptr_q];
    assign rx_full_sel = mr_q[0][RXSEL_BIT];

    // Once at the second register, stay until a pointer reset
    assert_ptr_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr_q && !ptr_rst) |=> ptr_q);
endmodule

// File: rtl/ucs_tx_hold.sv
// Transmit holding byte and transmitter enable. Sends the held byte with
// a one-cycle strobe when enabled, not empty and the transmitter is idle.
// Assumes a buffer load and a transmitter reset never coincide.
module ucs_tx_hold #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [DW-1:0] load_data,
    input  logic          tx_on,
    input  logic          tx_off,
    input  logic          tx_rst,
    input  logic          tx_busy,
    output logic          tx_en,
    output logic          tx_empty,
    output logic          tx_send,
    output logic [DW-1:0] tx_byte
);
    logic          en_q;
    logic          empty_q;
    logic [DW-1:0] hold_q;

    assign tx_send  = en_q && !empty_q && !tx_busy;
    assign tx_en    = en_q;
    assign tx_empty = empty_q;
    assign tx_byte  = hold_q;

    // Enable: field action wins over the reset in the same byte
    always_ff @(posedge clk) begin
        if (!rst_n)                 en_q <= 1'b0;
        else if (tx_on)             en_q <= 1'b1;
        else if (tx_off || tx_rst)  en_q <= 1'b0;
    end

    // Empty flag: a load clears it, a send or reset sets it
    always_ff @(posedge clk) begin
        if (!rst_n)                  empty_q <= 1'b1;
        else if (load)               empty_q <= 1'b0;
        else if (tx_send || tx_rst)  empty_q <= 1'b1;
    end

    // Holding byte capture
    always_ff @(posedge clk) begin
        if (!rst_n)    hold_q <= '0;
        else if (load) hold_q <= load_data;
    end

    assert_send_empties_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_send && !load) |=> tx_empty);
    assert_load_fills_R3: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> !tx_empty);
    assert_off_disables_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_off && !tx_on) |=> !tx_en);
endmodule

// File: rtl/ucs_rx_status.sv
// Receive-side status: receiver enable, FIFO level flags, sticky error
// flags and the delta-break flag. The FIFO itself lives outside.
module ucs_rx_status #(
    parameter int DEPTH = 4,
    parameter int LVL_W = $clog2(DEPTH + 1),
    parameter int NEVT  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LVL_W-1:0] rx_level,
    input  logic [NEVT-1:0]  rx_evt,
    input  logic             rx_on,
    input  logic             rx_off,
    input  logic             rx_rst,
    input  logic             err_rst,
    input  logic             brk_clr,
    output logic             rx_enabled,
    output logic             rx_accept,
    output logic             rx_ready,
    output logic             rx_full,
    output logic [NEVT-1:0]  err_flags,
    output logic             dbrk,
    output logic             rx_flush
);
    localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(DEPTH);
    localparam int BRK_IDX = NEVT - 1;

    logic            en_q;
    logic [NEVT-1:0] err_q;
    logic            dbrk_q;

    assign rx_ready   = (rx_level != '0);
    assign rx_full    = (rx_level == FULL_LVL);
    assign rx_enabled = en_q;
    assign rx_accept  = en_q && !rx_full;
    assign err_flags  = err_q;
    assign dbrk       = dbrk_q;
    assign rx_flush   = rx_rst;

    // Receiver enable: field action wins over the reset in the same byte
    always_ff @(posedge clk) begin
        if (!rst_n)                 en_q <= 1'b0;
        else if (rx_on)             en_q <= 1'b1;
        else if (rx_off || rx_rst)  en_q <= 1'b0;
    end

    // Sticky error flags, one per event line; clear wins
    for (genvar g = 0; g < NEVT; g++) begin : g_err
        always_ff @(posedge clk) begin
            if (!rst_n)         err_q[g] <= 1'b0;
            else if (err_rst)   err_q[g] <= 1'b0;
            else if (rx_evt[g]) err_q[g] <= 1'b1;
        end
    end

    // Delta-break flag; clear wins
    always_ff @(posedge clk) begin
        if (!rst_n)               dbrk_q <= 1'b0;
        else if (brk_clr)         dbrk_q <= 1'b0;
        else if (rx_evt[BRK_IDX]) dbrk_q <= 1'b1;
    end

    assert_rxrst_disables_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_rst && !rx_on) |=> !rx_enabled);
    assert_err_clear_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        err_rst |=> (err_flags == '0));
    assert_brk_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        brk_clr |=> !dbrk);
endmodule

// File: rtl/ucs_top.sv
// UART command and status controller top: register bus decode, read mux,
// interrupt status, mask, illegal-command flag and interrupt output.
// Assumes single-cycle strobes and never both read and write at once.
module ucs_top
    import ucs_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [AW-1:0]    bus_addr,
    input  logic             bus_wr,
    input  logic             bus_rd,
    input  logic [DW-1:0]    bus_wdata,
    output logic [DW-1:0]    bus_rdata,
    input  logic             tx_busy,
    output logic             tx_send,
    output logic [DW-1:0]    tx_byte,
    input  logic [LVL_W-1:0] rx_level,
    input  logic [DW-1:0]    rx_data,
    input  logic [3:0]       rx_evt,
    output logic             rx_pop,
    output logic             rx_flush,
    output logic             rx_accept,
    output logic             irq
);
    cmd_act_t      act;
    logic          mode_acc, mode_we, cmd_we, data_we, mask_we;
    logic [DW-1:0] mode_val;
    logic          rx_full_sel;
    logic          tx_en, tx_empty;
    logic          rx_enabled, rx_ready, rx_full, dbrk;
    logic [3:0]    err_flags;
    logic [DW-1:0] status, isr;
    logic [DW-1:0] mask_q;
    logic          illegal_q;

    // Address decode of the strobes
    assign mode_acc = (bus_wr || bus_rd) && (bus_addr == OFS_MODE);
    assign mode_we  = bus_wr && (bus_addr == OFS_MODE);
    assign cmd_we   = bus_wr && (bus_addr == OFS_CMD);
    assign data_we  = bus_wr && (bus_addr == OFS_DATA);
    assign mask_we  = bus_wr && (bus_addr == OFS_INT);
    assign rx_pop   = bus_rd && (bus_addr == OFS_DATA) && rx_ready;

    ucs_cmd_decode u_dec (
        .cmd_we   (cmd_we),
        .cmd_bits (bus_wdata[6:0]),
        .act      (act)
    );

    ucs_mode_regs #(.DW(DW), .RXSEL_BIT(6)) u_mode (
        .clk         (clk),
        .rst_n       (rst_n),
        .acc         (mode_acc),
        .we          (mode_we),
        .wdata       (bus_wdata),
        .ptr_rst     (act.ptr_rst),
        .rd_val      (mode_val),
        .rx_full_sel (rx_full_sel)
    );

    ucs_tx_hold #(.DW(DW)) u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (data_we),
        .load_data (bus_wdata),
        .tx_on     (act.tx_on),
        .tx_off    (act.tx_off),
        .tx_rst    (act.tx_rst),
        .tx_busy   (tx_busy),
        .tx_en     (tx_en),
        .tx_empty  (tx_empty),
        .tx_send   (tx_send),
        .tx_byte   (tx_byte)
    );

    ucs_rx_status #(.DEPTH(DEPTH), .LVL_W(LVL_W), .NEVT(4)) u_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .rx_level   (rx_level),
        .rx_evt     (rx_evt),
        .rx_on      (act.rx_on),
        .rx_off     (act.rx_off),
        .rx_rst     (act.rx_rst),
        .err_rst    (act.err_rst),
        .brk_clr    (act.brk_clr),
        .rx_enabled (rx_enabled),
        .rx_accept  (rx_accept),
        .rx_ready   (rx_ready),
        .rx_full    (rx_full),
        .err_flags  (err_flags),
        .dbrk       (dbrk),
        .rx_flush   (rx_flush)
    );

    // Status and interrupt status assembly
    assign status = {err_flags, tx_empty, tx_en, rx_full, rx_ready};
    assign isr    = {5'b0, dbrk, (rx_full_sel ? rx_full : rx_ready), tx_en};
    assign irq    = |(isr & mask_q);

    // Interrupt mask register
    always_ff @(posedge clk) begin
        if (!rst_n)       mask_q <= '0;
        else if (mask_we) mask_q <= bus_wdata;
    end

    // Sticky illegal-command flag, cleared by the error-reset command
    always_ff @(posedge clk) begin
        if (!rst_n)           illegal_q <= 1'b0;
        else if (act.err_rst) illegal_q <= 1'b0;
        else if (act.illegal) illegal_q <= 1'b1;
    end

    // Registered read data mux
    always_ff @(posedge clk) begin
        if (!rst_n) bus_rdata <= '0;
        else if (bus_rd) begin
            case (bus_addr)
                OFS_MODE: bus_rdata <= mode_val;
                OFS_STAT: bus_rdata <= status;
                OFS_DATA: bus_rdata <= rx_data;
                OFS_INT:  bus_rdata <= isr;
                OFS_FLAG: bus_rdata <= {7'b0, illegal_q};
                default:  bus_rdata <= '0;
            endcase
        end
    end

    assert_rsvd_tx_keeps_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_we && bus_wdata[3:2] == 2'd3 && bus_wdata[6:4] != 3'd3) |=> $stable(tx_en));
    assert_rsvd_flags_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (act.illegal && !act.err_rst) |=> illegal_q);
    assert_no_pop_empty_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rx_pop |-> (rx_level != '0));
endmodule

// File: tb/sim_ucs_top.sv
module sim_ucs_top;
    localparam time CLK_P = 20ns;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [5:0] bus_addr = '0;
    logic       bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       tx_busy = 1'b0;
    logic       tx_send;
    logic [7:0] tx_byte;
    logic [2:0] rx_level = '0;
    logic [7:0] rx_data = '0;
    logic [3:0] rx_evt = '0;
    logic       rx_pop, rx_flush, rx_accept, irq;

    int n_run = 0, n_fail = 0;
    int sends = 0, pops = 0, flushes = 0;
    logic [7:0] rv;

    always #(CLK_P/2) clk = ~clk;

    ucs_top u0 (.*);

    // Event counters on the design's strobes
    always @(posedge clk) begin
        if (rst_n && tx_send)  sends++;
        if (rst_n && rx_pop)   pops++;
        if (rst_n && rx_flush) flushes++;
    end

    task automatic check(string req, int got, int exp);
        n_run++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
        end
    endtask

    task automatic wr(logic [5:0] a, logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(logic [5:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic t_reset();
        rd(6'h04, rv); check("R1 status", rv, 8'h08);
        rd(6'h14, rv); check("R1 isr", rv, 8'h00);
        rd(6'h1C, rv); check("R1 flag", rv, 8'h00);
        check("R1 irq", irq, 0);
        check("R1 rx_accept", rx_accept, 0);
    endtask

    task automatic t_mode_ptr();
        wr(6'h00, 8'h21);
        wr(6'h00, 8'h17);
        wr(6'h00, 8'h99);
        wr(6'h08, 8'h10);
        rd(6'h00, rv); check("R2 first is MR1", rv, 8'h21);
        rd(6'h00, rv); check("R2 then MR2", rv, 8'h99);
        rd(6'h00, rv); check("R2 stays MR2", rv, 8'h99);
        wr(6'h08, 8'h10);
    endtask

    task automatic t_tx_hold();
        int s0 = sends;
        wr(6'h0C, 8'h5A);
        rd(6'h04, rv); check("R3 empty cleared", rv & 8'h0C, 8'h00);
        check("R3 no send disabled", sends - s0, 0);
        wr(6'h08, 8'h04);
        check("R3 send strobe", tx_send, 1);
        check("R3 send byte", tx_byte, 8'h5A);
        @(negedge clk);
        check("R3 single pulse", tx_send, 0);
        rd(6'h04, rv); check("R4 ready and empty", rv & 8'h0C, 8'h0C);
    endtask

    task automatic t_tx_busy();
        int s0 = sends;
        tx_busy = 1'b1;
        wr(6'h0C, 8'hC3);
        repeat (3) @(negedge clk);
        check("R3 held while busy", sends - s0, 0);
        rd(6'h04, rv); check("R3 busy status", rv & 8'h0C, 8'h04);
        tx_busy = 1'b0;
        #1;
        check("R3 send after busy", tx_send, 1);
        check("R3 byte after busy", tx_byte, 8'hC3);
        @(negedge clk);
    endtask

    task automatic t_tx_disable();
        wr(6'h08, 8'h08);
        rd(6'h04, rv); check("R4 disabled", rv & 8'h0C, 8'h08);
    endtask

    task automatic t_tx_reset();
        int s0;
        wr(6'h08, 8'h04);
        tx_busy = 1'b1;
        s0 = sends;
        wr(6'h0C, 8'h3E);
        wr(6'h08, 8'h30);
        rd(6'h04, rv); check("R7 tx reset status", rv & 8'h0C, 8'h08);
        tx_busy = 1'b0;
        repeat (2) @(negedge clk);
        check("R7 byte discarded", sends - s0, 0);
    endtask

    task automatic t_rx();
        int p0;
        wr(6'h08, 8'h01);
        check("R5 accept when enabled", rx_accept, 1);
        rx_level = 3'd2;
        rd(6'h04, rv); check("R6 ready not full", rv & 8'h03, 8'h01);
        rx_level = 3'd4;
        rd(6'h04, rv); check("R6 full", rv & 8'h03, 8'h03);
        check("R5 accept low when full", rx_accept, 0);
        rx_data = 8'h77;
        p0 = pops;
        rd(6'h0C, rv); check("R6 read data", rv, 8'h77);
        check("R6 one pop", pops - p0, 1);
        rx_level = 3'd0;
        p0 = pops;
        rd(6'h0C, rv);
        check("R6 no pop when empty", pops - p0, 0);
        wr(6'h08, 8'h02);
        check("R5 disabled", rx_accept, 0);
    endtask

    task automatic t_rx_reset();
        int f0 = flushes;
        wr(6'h08, 8'h01);
        wr(6'h08, 8'h20);
        check("R7 flush pulse", flushes - f0, 1);
        check("R7 rx disabled", rx_accept, 0);
    endtask

    task automatic t_err();
        @(negedge clk); rx_evt = 4'b0111;
        @(negedge clk); rx_evt = 4'b0000;
        rd(6'h04, rv); check("R8 sticky errors", rv & 8'hF0, 8'h70);
        @(negedge clk);
        bus_addr = 6'h08; bus_wdata = 8'h40; bus_wr = 1'b1; rx_evt = 4'b0001;
        @(negedge clk);
        bus_wr = 1'b0; rx_evt = 4'b0000;
        rd(6'h04, rv); check("R8 clear wins", rv & 8'hF0, 8'h00);
    endtask

    task automatic t_brk();
        @(negedge clk); rx_evt = 4'b1000;
        @(negedge clk); rx_evt = 4'b0000;
        rd(6'h14, rv); check("R9 delta-break set", rv & 8'h04, 8'h04);
        wr(6'h08, 8'h50);
        rd(6'h14, rv); check("R9 delta-break cleared", rv & 8'h04, 8'h00);
        rd(6'h04, rv); check("R9 break status kept", rv & 8'h80, 8'h80);
        wr(6'h08, 8'h40);
    endtask

    task automatic t_irq();
        wr(6'h14, 8'h01);
        wr(6'h08, 8'h04);
        check("R10 tx irq", irq, 1);
        wr(6'h08, 8'h08);
        check("R10 tx irq off", irq, 0);
        wr(6'h08, 8'h10);
        wr(6'h00, 8'h40);
        wr(6'h14, 8'h02);
        rx_level = 3'd2;
        @(negedge clk);
        check("R10 full mode not full", irq, 0);
        rd(6'h14, rv); check("R10 isr full mode", rv & 8'h03, 8'h00);
        rx_level = 3'd4;
        @(negedge clk);
        check("R10 full mode full", irq, 1);
        wr(6'h08, 8'h10);
        wr(6'h00, 8'h00);
        rx_level = 3'd1;
        @(negedge clk);
        check("R10 ready mode", irq, 1);
        rx_level = 3'd0;
        wr(6'h14, 8'h00);
    endtask

    task automatic t_illegal();
        wr(6'h08, 8'h04);
        wr(6'h08, 8'h0C);
        rd(6'h04, rv); check("R11 tx enable kept", rv & 8'h04, 8'h04);
        rd(6'h1C, rv); check("R11 flag set", rv, 8'h01);
        wr(6'h08, 8'h40);
        rd(6'h1C, rv); check("R11 flag cleared", rv, 8'h00);
        wr(6'h08, 8'h01);
        wr(6'h08, 8'h03);
        check("R11 rx enable kept", rx_accept, 1);
        rd(6'h1C, rv); check("R11 rx flag", rv, 8'h01);
        wr(6'h08, 8'h4A);
    endtask

    task automatic t_order();
        logic [7:0] s0, i0;
        wr(6'h08, 8'h34);
        rd(6'h04, rv); check("R12 reset then enable", rv & 8'h0C, 8'h0C);
        rd(6'h04, s0);
        rd(6'h14, i0);
        wr(6'h08, 8'h60);
        wr(6'h08, 8'h70);
        wr(6'h08, 8'h00);
        rd(6'h04, rv); check("R12 no-op status", rv, s0);
        rd(6'h14, rv); check("R12 no-op isr", rv, i0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        fork
            begin
                t_reset();
                t_mode_ptr();
                t_tx_hold();
                t_tx_busy();
                t_tx_disable();
                t_tx_reset();
                t_rx();
                t_rx_reset();
                t_err();
                t_brk();
                t_irq();
                t_illegal();
                t_order();
            end
            begin
                repeat (100000) @(posedge clk);
                n_run++; n_fail++;
                $display("FAIL watchdog: got timeout expected completion");
            end
        join_any
        disable fork;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule